// File: doc/BRIEF.md
# Vector Length Set Unit

This unit executes one instruction that sets the vector length and the maximum vector length. When the valid strobe is high, it decodes the 32-bit instruction word in that cycle. It chooses a candidate length from one of three sources: the held length, the 7-bit immediate, or a 64-bit general register read through a combinational read port. It also chooses a new maximum from the immediate or from the held maximum. The candidate is clamped to that maximum, and both length registers are stored. The final length can also be written to a destination register, together with a 4-bit condition field.

The results are registered. The length registers change at the clock edge that samples the strobe. The write-back pulses (register write, condition write, illegal flag) are valid for exactly the one cycle that follows that edge.

A small enumerated write-back state register drives the output pulses. Its states are:
- `WB_IDLE`: no strobe.
- `WB_SPR`: only the length registers were written.
- `WB_SPR_GPR`: the destination register is written as well.
- `WB_SPR_GPR_CR`: the condition field is written as well.
- `WB_ILLEGAL`: the opcode did not match.

Every edge is a transition. From any state, the unit moves to:
- `WB_IDLE` when the strobe is low.
- `WB_ILLEGAL` when the strobe is high and the opcode does not match.
- `WB_SPR` when the destination field is zero.
- `WB_SPR_GPR_CR` when the destination field is nonzero and the record flag is set.
- `WB_SPR_GPR` otherwise.

Top module: `vlset_unit`

## Requirements
- R1: A strobed word whose six most significant bits (big-endian bits 0..5, `insn_i[31:26]`) are not 19 raises `illegal_o` for the next cycle. In that case the length registers stay unchanged and no register or condition write is pulsed.
- R2: The fields are decoded in big-endian bit numbering (bit n = `insn_i[31-n]`). Destination is bits 6..10, source index is bits 11..15, immediate is bits 16..22, length-select flag is bit 24 (`insn_i[7]`), max-select flag is bit 25 (`insn_i[6]`), and record flag is bit 31 (`insn_i[0]`). `ra_addr_o` always equals the source-index field.
- R3: With the length-select flag set and the source index zero, the candidate length is the held length.
- R4: With the length-select flag set and the source index nonzero, the candidate length is the immediate.
- R5: With the length-select flag clear and the source index nonzero, the candidate length is `ra_data_i`.
- R6: With the length-select flag clear and the source index zero, the candidate is the held length, which is still clamped to the new maximum.
- R7: The new maximum is the immediate when the max-select flag is set, and the held maximum otherwise.
- R8: The stored length is the unsigned minimum of the 64-bit candidate and the new maximum, so any candidate at or above the maximum yields the maximum.
- R9: With a nonzero destination, `gpr_we_o` pulses with `gpr_waddr_o` equal to the destination and `gpr_wdata_o` equal to the zero-extended final length. With a zero destination, no write is pulsed.
- R10: With a nonzero destination and the record flag set, `cr_we_o` pulses with `cr_field_o = {LT=0, GT=(length>0), EQ=(length==0), SO=so_i}`, bit 3 down to bit 0.
- R11: A synchronous reset clears both length registers and all pulses. Without a strobe nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| so_i | input | 1 | Summary-overflow bit copied into the condition field |
| ra_addr_o | output | 5 | Register-file read index (source field) |
| ra_data_i | input | 64 | Register-file read data for `ra_addr_o` |
| vl_o | output | 7 | Held vector length |
| mvl_o | output | 7 | Held maximum vector length |
| gpr_we_o | output | 1 | Destination register write pulse |
| gpr_waddr_o | output | 5 | Destination register index |
| gpr_wdata_o | output | 64 | Destination register write data |
| cr_we_o | output | 1 | Condition field write pulse |
| cr_field_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| illegal_o | output | 1 | Illegal-opcode pulse |

## Verification
The hardest case to reach is the clamp of a register operand whose upper bits are set while its low seven bits are small. A comparison truncated to the register width would accept that value. To expose this, the bench preloads its register model with values such as 2^63+2 and 256. It raises the maximum first, and then selects those registers as the length source. The held-length path with a shrinking maximum is reached the same way: a nonzero length is established first, and then a smaller maximum is imposed with the source index at zero.

// File: rtl/vlset_pkg.sv
package vlset_pkg;

    localparam int INSN_W     = 32;
    localparam int RIDX_W     = 5;
    localparam int IMM_W      = 7;
    localparam int OPC_W      = 6;
    localparam int CR_W       = 4;
    localparam logic [OPC_W-1:0] OPC_VLSET = 6'd19;

    // source of the candidate vector length
    typedef enum logic [1:0] {
        VSRC_HELD = 2'd0,
        VSRC_IMM  = 2'd1,
        VSRC_GPR  = 2'd2
    } vl_src_e;

    // write-back state held for the cycle after a strobe
    typedef enum logic [2:0] {
        WB_IDLE       = 3'd0,
        WB_SPR        = 3'd1,
        WB_SPR_GPR    = 3'd2,
        WB_SPR_GPR_CR = 3'd3,
        WB_ILLEGAL    = 3'd4
    } wb_state_e;

    typedef struct packed {
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] ra;
        logic [IMM_W-1:0]  imm;
        logic              vs;
        logic              ms;
        logic              rc;
    } vlset_fields_t;

    // big-endian bit index to little-endian vector index
    function automatic int be2le(input int width, input int be_bit);
        return width - 1 - be_bit;
    endfunction

endpackage

// File: rtl/vlset_decode.sv
module vlset_decode
    import vlset_pkg::*;
#(
    parameter int W = INSN_W
) (
    input  logic [W-1:0]  insn,
    output logic          opc_ok,
    output vlset_fields_t fld,
    output vl_src_e       vl_src
);

    // field boundaries in big-endian numbering
    localparam int OPC_HI = be2le(W, 0);
    localparam int OPC_LO = be2le(W, 5);
    localparam int RT_HI  = be2le(W, 6);
    localparam int RT_LO  = be2le(W, 10);
    localparam int RA_HI  = be2le(W, 11);
    localparam int RA_LO  = be2le(W, 15);
    localparam int IMM_HI = be2le(W, 16);
    localparam int IMM_LO = be2le(W, 22);
    localparam int VS_BIT = be2le(W, 24);
    localparam int MS_BIT = be2le(W, 25);
    localparam int RC_BIT = be2le(W, 31);

    logic ra_zero;

    always_comb begin
        opc_ok  = (insn[OPC_HI:OPC_LO] == OPC_VLSET);
        fld.rt  = insn[RT_HI:RT_LO];
        fld.ra  = insn[RA_HI:RA_LO];
        fld.imm = insn[IMM_HI:IMM_LO];
        fld.vs  = insn[VS_BIT];
        fld.ms  = insn[MS_BIT];
        fld.rc  = insn[RC_BIT];
        ra_zero = (fld.ra == '0);
    end

    // candidate source: mode flag and zero-ness of the index together
    always_comb begin
        unique case ({fld.vs, ra_zero})
            2'b11:   vl_src = VSRC_HELD;
            2'b10:   vl_src = VSRC_IMM;
            2'b00:   vl_src = VSRC_GPR;
            default: vl_src = VSRC_HELD;
        endcase
    end

    always_comb begin
        // R4: an immediate source always comes with a nonzero index
        assert (!(vl_src == VSRC_IMM && ra_zero)) else $error("p_imm_src_r4");
        // R5: a register source always comes with a nonzero index
        assert (!(vl_src == VSRC_GPR && ra_zero)) else $error("p_gpr_src_r5");
    end

endmodule

// File: rtl/vlset_select.sv
module vlset_select
    import vlset_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLW  = IMM_W
) (
    input  vl_src_e          vl_src,
    input  logic             ms,
    input  logic [VLW-1:0]   imm,
    input  logic [VLW-1:0]   cur_vl,
    input  logic [VLW-1:0]   cur_mvl,
    input  logic [XLEN-1:0]  gpr_val,
    output logic [VLW-1:0]   new_vl,
    output logic [VLW-1:0]   new_mvl
);

    localparam int PAD = XLEN - VLW;

    logic [XLEN-1:0] cand;
    logic [XLEN-1:0] mvl_wide;
    logic            cand_below;

    always_comb begin
        unique case (vl_src)
            VSRC_IMM:  cand = {{PAD{1'b0}}, imm};
            VSRC_GPR:  cand = gpr_val;
            default:   cand = {{PAD{1'b0}}, cur_vl};
        endcase
    end

    always_comb begin
        new_mvl    = ms ? imm : cur_mvl;
        mvl_wide   = {{PAD{1'b0}}, new_mvl};
        // full-width unsigned compare
        cand_below = (cand < mvl_wide);
        new_vl     = cand_below ? cand[VLW-1:0] : new_mvl;
    end

endmodule

// File: rtl/vlset_wb.sv
module vlset_wb
    import vlset_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLW  = IMM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              opc_ok,
    input  logic [RIDX_W-1:0] rt,
    input  logic              rc,
    input  logic              so,
    input  logic [VLW-1:0]    new_vl,
    input  logic [VLW-1:0]    new_mvl,
    output logic [VLW-1:0]    vl_q,
    output logic [VLW-1:0]    mvl_q,
    output logic              gpr_we,
    output logic [RIDX_W-1:0] gpr_waddr,
    output logic [XLEN-1:0]   gpr_wdata,
    output logic              cr_we,
    output logic [CR_W-1:0]   cr_field,
    output logic              illegal
);

    wb_state_e         state_q, state_d;
    logic [RIDX_W-1:0] rt_q;
    logic              so_q;
    logic              commit;

    // next state from strobe and decode
    always_comb begin
        if (!valid)            state_d = WB_IDLE;
        else if (!opc_ok)      state_d = WB_ILLEGAL;
        else if (rt == '0)     state_d = WB_SPR;
        else if (rc)           state_d = WB_SPR_GPR_CR;
        else                   state_d = WB_SPR_GPR;
        commit = (state_d == WB_SPR) || (state_d == WB_SPR_GPR) ||
                 (state_d == WB_SPR_GPR_CR);
    end

    // state and data registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WB_IDLE;
            vl_q    <= '0;
            mvl_q   <= '0;
            rt_q    <= '0;
            so_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (commit) begin
                vl_q  <= new_vl;
                mvl_q <= new_mvl;
                rt_q  <= rt;
                so_q  <= so;
            end
        end
    end

    // outputs decoded from the held state
    always_comb begin
        gpr_we  = 1'b0;
        cr_we   = 1'b0;
        illegal = 1'b0;
        unique case (state_q)
            WB_IDLE:       ;
            WB_SPR:        ;
            WB_SPR_GPR:    gpr_we = 1'b1;
            WB_SPR_GPR_CR: begin
                gpr_we = 1'b1;
                cr_we  = 1'b1;
            end
            WB_ILLEGAL:    illegal = 1'b1;
            default:       ;
        endcase
        gpr_waddr = rt_q;
        gpr_wdata = {{(XLEN-VLW){1'b0}}, vl_q};
        cr_field  = {1'b0, (vl_q != '0), (vl_q == '0), so_q};
    end

    // R8: the held length never exceeds the held maximum
    p_clamp_r8: assert property (@(posedge clk) disable iff (rst)
        vl_q <= mvl_q);

    // R9: a register write never targets index zero
    p_rt_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (gpr_waddr != '0));

    // R10: condition write rides on a register write, LT clear, GT/EQ exclusive
    p_cr_field_r10: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> (gpr_we && !cr_field[3] && (cr_field[2] != cr_field[1])));

    // R11: idle or illegal cycles leave the length registers untouched
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == WB_IDLE || state_q == WB_ILLEGAL) |->
            ($stable(vl_q) && $stable(mvl_q)));

endmodule

// File: rtl/vlset_unit.sv
module vlset_unit
    import vlset_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLW  = IMM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [31:0]       insn_i,
    input  logic              so_i,
    output logic [RIDX_W-1:0] ra_addr_o,
    input  logic [XLEN-1:0]   ra_data_i,
    output logic [VLW-1:0]    vl_o,
    output logic [VLW-1:0]    mvl_o,
    output logic              gpr_we_o,
    output logic [RIDX_W-1:0] gpr_waddr_o,
    output logic [XLEN-1:0]   gpr_wdata_o,
    output logic              cr_we_o,
    output logic [CR_W-1:0]   cr_field_o,
    output logic              illegal_o
);

    logic          opc_ok;
    vlset_fields_t fld;
    vl_src_e       vl_src;
    logic [VLW-1:0] new_vl, new_mvl;

    vlset_decode #(.W(INSN_W)) u_dec (
        .insn   (insn_i),
        .opc_ok (opc_ok),
        .fld    (fld),
        .vl_src (vl_src)
    );

    assign ra_addr_o = fld.ra;

    vlset_select #(.XLEN(XLEN), .VLW(VLW)) u_sel (
        .vl_src  (vl_src),
        .ms      (fld.ms),
        .imm     (fld.imm),
        .cur_vl  (vl_o),
        .cur_mvl (mvl_o),
        .gpr_val (ra_data_i),
        .new_vl  (new_vl),
        .new_mvl (new_mvl)
    );

    vlset_wb #(.XLEN(XLEN), .VLW(VLW)) u_wb (
        .clk       (clk),
        .rst       (rst),
        .valid     (valid_i),
        .opc_ok    (opc_ok),
        .rt        (fld.rt),
        .rc        (fld.rc),
        .so        (so_i),
        .new_vl    (new_vl),
        .new_mvl   (new_mvl),
        .vl_q      (vl_o),
        .mvl_q     (mvl_o),
        .gpr_we    (gpr_we_o),
        .gpr_waddr (gpr_waddr_o),
        .gpr_wdata (gpr_wdata_o),
        .cr_we     (cr_we_o),
        .cr_field  (cr_field_o),
        .illegal   (illegal_o)
    );

    // R1: a strobed foreign opcode raises the illegal pulse next cycle
    p_bad_opc_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(valid_i) && $past(insn_i[31:26]) != OPC_VLSET)
            |-> illegal_o);

    // R1: an illegal cycle writes nothing and keeps the lengths
    p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!gpr_we_o && !cr_we_o && $stable(vl_o) && $stable(mvl_o)));

    // R11: no pulse appears without a preceding strobe
    p_no_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(valid_i) |-> (!gpr_we_o && !cr_we_o && !illegal_o));

endmodule

// File: tb/vlset_unit_tb.sv
module vlset_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [31:0] insn_i;
    logic        so_i;
    logic [4:0]  ra_addr_o;
    logic [63:0] ra_data_i;
    logic [6:0]  vl_o, mvl_o;
    logic        gpr_we_o;
    logic [4:0]  gpr_waddr_o;
    logic [63:0] gpr_wdata_o;
    logic        cr_we_o;
    logic [3:0]  cr_field_o;
    logic        illegal_o;

    logic [63:0] gpr [32];
    logic [6:0]  exp_vl, exp_mvl;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign ra_data_i = gpr[ra_addr_o];

    vlset_unit dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i), .so_i(so_i),
        .ra_addr_o(ra_addr_o), .ra_data_i(ra_data_i), .vl_o(vl_o), .mvl_o(mvl_o),
        .gpr_we_o(gpr_we_o), .gpr_waddr_o(gpr_waddr_o), .gpr_wdata_o(gpr_wdata_o),
        .cr_we_o(cr_we_o), .cr_field_o(cr_field_o), .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                       input logic [4:0] ra, input logic [6:0] imm,
                                       input logic vs, input logic ms, input logic rc);
        logic [31:0] w = '0;
        w[31:26] = op; w[25:21] = rt; w[20:16] = ra; w[15:9] = imm;
        w[7] = vs; w[6] = ms; w[0] = rc;
        return w;
    endfunction

    // one strobed instruction; expected results from the requirements
    task automatic run(input string req, input logic [5:0] op, input logic [4:0] rt,
                       input logic [4:0] ra, input logic [6:0] imm, input logic vs,
                       input logic ms, input logic rc, input logic so);
        logic [63:0] cand;
        logic [6:0]  nmvl, nvl;
        bit          legal = (op == 6'd19);
        if (vs) cand = (ra == 0) ? {57'b0, exp_vl} : {57'b0, imm};
        else    cand = (ra == 0) ? {57'b0, exp_vl} : gpr[ra];
        nmvl = ms ? imm : exp_mvl;
        nvl  = (cand < {57'b0, nmvl}) ? cand[6:0] : nmvl;
        @(negedge clk);
        insn_i = mk(op, rt, ra, imm, vs, ms, rc);
        so_i = so; valid_i = 1'b1;
        #1;
        chk(ra_addr_o == ra, "R2", "read index", ra_addr_o, ra);
        @(negedge clk);
        valid_i = 1'b0;
        if (legal) begin exp_vl = nvl; exp_mvl = nmvl; end
        chk(illegal_o == !legal, req, "illegal", illegal_o, !legal);
        chk(vl_o == exp_vl, req, "vl", vl_o, exp_vl);
        chk(mvl_o == exp_mvl, req, "mvl", mvl_o, exp_mvl);
        chk(gpr_we_o == (legal && rt != 0), req, "gpr_we", gpr_we_o, legal && rt != 0);
        if (legal && rt != 0) begin
            chk(gpr_waddr_o == rt, req, "waddr", gpr_waddr_o, rt);
            chk(gpr_wdata_o == {57'b0, exp_vl}, req, "wdata", gpr_wdata_o, exp_vl);
        end
        chk(cr_we_o == (legal && rt != 0 && rc), req, "cr_we", cr_we_o,
            legal && rt != 0 && rc);
        if (legal && rt != 0 && rc)
            chk(cr_field_o == {1'b0, exp_vl != 0, exp_vl == 0, so}, req, "cr_field",
                cr_field_o, {1'b0, exp_vl != 0, exp_vl == 0, so});
    endtask

    task automatic t_reset;
        rst = 1'b1; valid_i = 1'b0; insn_i = '0; so_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_vl = 0; exp_mvl = 0;
        chk(vl_o == 0 && mvl_o == 0, "R11", "reset lengths", {vl_o, mvl_o}, 0);
        chk(!gpr_we_o && !cr_we_o && !illegal_o, "R11", "reset pulses",
            {gpr_we_o, cr_we_o, illegal_o}, 0);
    endtask

    task automatic t_immediates;
        run("R4", 6'd19, 5'd3, 5'd1, 7'd40, 1, 1, 0, 0);   // R7 max from imm, R9 write
        run("R4", 6'd19, 5'd0, 5'd1, 7'd10, 1, 0, 0, 0);   // R9 rt zero, R7 held max
        run("R3", 6'd19, 5'd5, 5'd0, 7'd5, 1, 1, 0, 0);    // held 10 clamps to 5
        run("R7", 6'd19, 5'd0, 5'd0, 7'd100, 1, 1, 0, 0);  // max raised, vl kept
    endtask

    task automatic t_gpr_source;
        run("R5", 6'd19, 5'd2, 5'd7, 7'd0, 0, 0, 0, 0);    // 33
        run("R8", 6'd19, 5'd2, 5'd8, 7'd0, 0, 0, 0, 0);    // high bit set -> 100
        run("R8", 6'd19, 5'd2, 5'd9, 7'd0, 0, 0, 0, 0);    // 256 -> 100
        run("R8", 6'd19, 5'd2, 5'd10, 7'd0, 0, 0, 0, 0);   // 99 just below
    endtask

    task automatic t_hold;
        run("R6", 6'd19, 5'd4, 5'd0, 7'd0, 0, 0, 0, 0);    // keep 99
        run("R6", 6'd19, 5'd4, 5'd0, 7'd20, 0, 1, 0, 0);   // kept value clamps to 20
    endtask

    task automatic t_condition;
        run("R10", 6'd19, 5'd4, 5'd0, 7'd0, 1, 0, 1, 1);   // GT with SO
        run("R10", 6'd19, 5'd0, 5'd0, 7'd0, 1, 0, 1, 0);   // rt zero -> no cr
        run("R10", 6'd19, 5'd6, 5'd0, 7'd0, 1, 1, 1, 0);   // zero length -> EQ
        run("R10", 6'd19, 5'd6, 5'd1, 7'd12, 1, 1, 1, 1);  // back to 12
    endtask

    task automatic t_illegal;
        run("R1", 6'd31, 5'd3, 5'd1, 7'd3, 1, 1, 1, 0);
        run("R1", 6'd18, 5'd3, 5'd7, 7'd3, 0, 1, 0, 0);
    endtask

    task automatic t_no_strobe;
        @(negedge clk);
        insn_i = mk(6'd19, 5'd3, 5'd1, 7'd1, 1, 1, 1);
        repeat (3) @(negedge clk);
        chk(vl_o == exp_vl && mvl_o == exp_mvl, "R11", "no strobe lengths",
            {vl_o, mvl_o}, {exp_vl, exp_mvl});
        chk(!gpr_we_o && !cr_we_o && !illegal_o, "R11", "no strobe pulses",
            {gpr_we_o, cr_we_o, illegal_o}, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_vl = 0; exp_mvl = 0;
        chk(vl_o == 0 && mvl_o == 0, "R11", "mid-run reset", {vl_o, mvl_o}, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) gpr[i] = 64'(i * 3);
        gpr[7]  = 64'd33;
        gpr[8]  = 64'h8000_0000_0000_0002;
        gpr[9]  = 64'd256;
        gpr[10] = 64'd99;
        t_reset();
        t_immediates();
        t_gpr_source();
        t_hold();
        t_condition();
        t_illegal();
        t_no_strobe();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule